// File: doc/BRIEF.md
# Machine Timer Bus Slave

This block is the machine-level timer of a RISC-V system, reached as a slave on a 32-bit pipelined Wishbone B4 bus. It holds a free-running 64-bit time counter and a 64-bit compare value. It also exposes a read-only 64-bit constant that gives the tick rate of the counter in hertz. Because the bus carries only whole 32-bit words, each 64-bit register is read or written as two halves. One address bit picks the half.

The counter advances by one on every clock, so software reads the tick rate from the constant register. The interrupt line is a level. It is high while the counter is at or above the compare value, and software clears it by writing a larger compare value. Every accepted bus request is answered one cycle later, and the slave never stalls. Back-to-back requests therefore run at one per clock.

Top module: `mtimer_wb`

## Requirements
- R1: After reset the time counter is zero, the compare register is all ones, and irq_o, ack_o and stall_o are low.
- R2: On every clock in which the time counter is not written, it increases by one, modulo 2^64.
- R3: Address bits [4:3] choose the register. 00 is the time counter (read/write), 01 is the compare register (read/write), 10 is the tick-rate constant (read-only) and 11 is unused. Address bits [1:0] have no effect.
- R4: Address bit 2 chooses the half of the register: 0 is bits [31:0] and 1 is bits [63:32].
- R5: A write to a half of the time counter loads that half with the write data. The other half keeps its value, and there is no increment in that cycle.
- R6: A write to a half of the compare register loads that half. The compare register changes at no other time.
- R7: A read of code 10 returns the matching half of the CLK_FREQ_HZ parameter. A read of code 11 returns zero. Writes to code 10 or code 11 are acknowledged and change no register.
- R8: irq_o is high exactly while the time counter is greater than or equal to the compare register, compared as unsigned 64-bit values.
- R9: A request is accepted when cyc_i and stb_i are both high. ack_o is high in the cycle after each accepted request and low in every other cycle. stall_o is always low.
- R10: Read data presented with ack_o is the register half as it stood in the cycle the request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the counter ticks on each rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Request strobe |
| we_i | input | 1 | High for a write, low for a read |
| adr_i | input | 5 | Byte address: [4:3] register code, [2] half select |
| dat_i | input | 32 | Write data |
| ack_o | output | 1 | Request acknowledge, one cycle after acceptance |
| stall_o | output | 1 | Stall, held low |
| dat_o | output | 32 | Read data, valid with ack_o |
| irq_o | output | 1 | Timer interrupt level |

## Verification
The assertions assume that the master never holds stb_i high without cyc_i when it intends a transfer. They also assume that the clock keeps running through reset, so that the registers reach their reset values before the first request. The bench drives only whole-clock requests at falling edges. It exercises both legal and unused register codes with arbitrary values in address bits [1:0], and it sets cyc_i low with stb_i high to confirm that such a request is ignored. The level-interrupt assertion excludes cycles that write a register and the cycle in which the counter wraps. To test the unsigned compare across the wrap, the bench loads the counter next to 2^64 and lets it run through the wrap.

// File: rtl/mtimer_pkg.sv
// Shared widths and register codes for the machine timer slave.
// Assumes a bus word that divides the 64-bit register width evenly.
package mtimer_pkg;
    localparam int REG_W  = 64;
    localparam int BUS_W  = 32;
    localparam int ADR_W  = 5;
    localparam int HALVES = REG_W / BUS_W;

    typedef enum logic [1:0] {
        RC_TIME = 2'b00,
        RC_CMP  = 2'b01,
        RC_FREQ = 2'b10,
        RC_NONE = 2'b11
    } reg_code_e;
endpackage

// File: rtl/mtimer_wordreg.sv
// A wide register written one bus word at a time.
// With FREE_RUN set it counts up by one in every cycle without a write.
// Assumes REG_W is a multiple of WORD_W.
module mtimer_wordreg #(
    parameter int REG_W  = 64,
    parameter int WORD_W = 32,
    parameter logic [REG_W-1:0] RESET_VAL = '0,
    parameter bit FREE_RUN = 1'b0
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [REG_W/WORD_W-1:0]   wr_en_i,
    input  logic [WORD_W-1:0]         wr_data_i,
    output logic [REG_W-1:0]          value_o
);
    localparam int WORDS = REG_W / WORD_W;

    logic [REG_W-1:0] value_q;
    logic [REG_W-1:0] merged;
    logic [REG_W-1:0] value_d;

    // Replace each written word and keep the others.
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        assign merged[w*WORD_W +: WORD_W] = wr_en_i[w] ? wr_data_i
                                                      : value_q[w*WORD_W +: WORD_W];
    end

    // Choose the next value: a write wins over the increment.
    if (FREE_RUN) begin : g_count
        assign value_d = (|wr_en_i) ? merged : value_q + 1'b1;
    end else begin : g_hold
        assign value_d = merged;
    end

    // Register the value, loading RESET_VAL while reset is low.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) value_q <= RESET_VAL;
        else         value_q <= value_d;
    end

    assign value_o = value_q;
endmodule

// File: rtl/mtimer_irq.sv
// Interrupt level: an unsigned comparison of the counter with the compare value.
// Assumes both inputs come straight from registers, so irq changes only after a clock.
module mtimer_irq #(
    parameter int REG_W = 64
) (
    input  logic [REG_W-1:0] time_i,
    input  logic [REG_W-1:0] cmp_i,
    output logic             irq_o
);
    // Raise the level while the counter has reached the compare value.
    always_comb irq_o = (time_i >= cmp_i);
endmodule

// File: rtl/mtimer_bus.sv
// Bus side of the timer: request decode, word write enables, ack and read mux.
// Answers every accepted request in the next cycle and never stalls.
// Assumes a request counts only while cyc and stb are both high.
module mtimer_bus
    import mtimer_pkg::*;
#(
    parameter logic [REG_W-1:0] FREQ_VAL = 64'd100_000_000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cyc_i,
    input  logic              stb_i,
    input  logic              we_i,
    input  logic [ADR_W-1:0]  adr_i,
    input  logic [REG_W-1:0]  time_i,
    input  logic [REG_W-1:0]  cmp_i,
    output logic [HALVES-1:0] time_wr_o,
    output logic [HALVES-1:0] cmp_wr_o,
    output logic              ack_o,
    output logic [BUS_W-1:0]  dat_o
);
    reg_code_e         code;
    logic              half;
    logic              accept;
    logic [HALVES-1:0] half_en;
    logic [BUS_W-1:0]  rd_word;
    logic [1:0]        unused_byte_adr;

    assign code            = reg_code_e'(adr_i[4:3]);
    assign half            = adr_i[2];
    assign accept          = cyc_i && stb_i;
    assign unused_byte_adr = adr_i[1:0];

    // Turn the half-select bit into a one-hot word enable.
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        assign half_en[h] = (half == h[0]);
    end

    // Gate word enables to the writable registers only.
    always_comb begin
        time_wr_o = '0;
        cmp_wr_o  = '0;
        if (accept && we_i) begin
            if (code == RC_TIME) time_wr_o = half_en;
            if (code == RC_CMP)  cmp_wr_o  = half_en;
        end
    end

    // Pick the addressed half for a read; the unused code reads zero.
    always_comb begin
        unique case (code)
            RC_TIME: rd_word = time_i[half*BUS_W +: BUS_W];
            RC_CMP:  rd_word = cmp_i[half*BUS_W +: BUS_W];
            RC_FREQ: rd_word = FREQ_VAL[half*BUS_W +: BUS_W];
            default: rd_word = '0;
        endcase
    end

    // Acknowledge one cycle after acceptance and capture read data.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ack_o <= 1'b0;
            dat_o <= '0;
        end else begin
            ack_o <= accept;
            if (accept && !we_i) dat_o <= rd_word;
        end
    end
endmodule

// File: rtl/mtimer_wb.sv
// Machine timer slave: 64-bit counter, 64-bit compare and tick-rate constant
// on a 32-bit pipelined bus, with a level interrupt.
// Assumes the counter clock is the bus clock running at CLK_FREQ_HZ.
module mtimer_wb
    import mtimer_pkg::*;
#(
    parameter logic [63:0] CLK_FREQ_HZ = 64'd100_000_000
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        cyc_i,
    input  logic        stb_i,
    input  logic        we_i,
    input  logic [4:0]  adr_i,
    input  logic [31:0] dat_i,
    output logic        ack_o,
    output logic        stall_o,
    output logic [31:0] dat_o,
    output logic        irq_o
);
    logic [REG_W-1:0]  mtime_val;
    logic [REG_W-1:0]  mtimecmp_val;
    logic [HALVES-1:0] time_wr;
    logic [HALVES-1:0] cmp_wr;

    assign stall_o = 1'b0;

    mtimer_bus #(.FREQ_VAL(CLK_FREQ_HZ)) u_bus (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .cyc_i    (cyc_i),
        .stb_i    (stb_i),
        .we_i     (we_i),
        .adr_i    (adr_i),
        .time_i   (mtime_val),
        .cmp_i    (mtimecmp_val),
        .time_wr_o(time_wr),
        .cmp_wr_o (cmp_wr),
        .ack_o    (ack_o),
        .dat_o    (dat_o)
    );

    mtimer_wordreg #(
        .REG_W(REG_W), .WORD_W(BUS_W), .RESET_VAL('0), .FREE_RUN(1'b1)
    ) u_time (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (time_wr),
        .wr_data_i(dat_i),
        .value_o  (mtime_val)
    );

    mtimer_wordreg #(
        .REG_W(REG_W), .WORD_W(BUS_W), .RESET_VAL('1), .FREE_RUN(1'b0)
    ) u_cmp (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (cmp_wr),
        .wr_data_i(dat_i),
        .value_o  (mtimecmp_val)
    );

    mtimer_irq #(.REG_W(REG_W)) u_irq (
        .time_i(mtime_val),
        .cmp_i (mtimecmp_val),
        .irq_o (irq_o)
    );
endmodule

// File: rtl/mtimer_checks.sv
// Properties of the machine timer slave, attached to every instance by bind.
// Assumes requests change only between clock edges.
module mtimer_checks #(
    parameter logic [63:0] CLK_FREQ_HZ = 64'd100_000_000
) (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        cyc_i,
    input logic        stb_i,
    input logic        we_i,
    input logic [4:0]  adr_i,
    input logic [31:0] dat_i,
    input logic        ack_o,
    input logic        stall_o,
    input logic [31:0] dat_o,
    input logic        irq_o,
    input logic [63:0] mtime_i,
    input logic [63:0] mtimecmp_i
);
    logic acc, wr_any, wr_time, wr_time_lo, wr_cmp, rd_freq;
    assign acc        = cyc_i && stb_i;
    assign wr_any     = acc && we_i;
    assign wr_time    = wr_any && (adr_i[4:3] == 2'b00);
    assign wr_time_lo = wr_time && !adr_i[2];
    assign wr_cmp     = wr_any && (adr_i[4:3] == 2'b01);
    assign rd_freq    = acc && !we_i && (adr_i[4:3] == 2'b10);

    assert_reset_values_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (mtime_i == 64'd0 && mtimecmp_i == '1 && !irq_o));

    assert_counter_ticks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_time |=> mtime_i == $past(mtime_i) + 64'd1);

    assert_low_write_keeps_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_time_lo |=> (mtime_i[31:0] == $past(dat_i) && mtime_i[63:32] == $past(mtime_i[63:32])));

    assert_cmp_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_cmp |=> $stable(mtimecmp_i));

    assert_freq_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_freq |=> dat_o == ($past(adr_i[2]) ? CLK_FREQ_HZ[63:32] : CLK_FREQ_HZ[31:0]));

    assert_irq_level_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && !wr_any && mtime_i != '1) |=> irq_o);

    assert_ack_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc |=> ack_o);

    assert_no_stray_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !acc |=> !ack_o);

    assert_never_stalls_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !stall_o);
endmodule

bind mtimer_wb mtimer_checks #(.CLK_FREQ_HZ(CLK_FREQ_HZ)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cyc_i     (cyc_i),
    .stb_i     (stb_i),
    .we_i      (we_i),
    .adr_i     (adr_i),
    .dat_i     (dat_i),
    .ack_o     (ack_o),
    .stall_o   (stall_o),
    .dat_o     (dat_o),
    .irq_o     (irq_o),
    .mtime_i   (mtime_val),
    .mtimecmp_i(mtimecmp_val)
);

// File: tb/sim_mtimer_wb.sv
// Bench for the machine timer slave: a behavioural model of the counter, the
// compare value and the bus reply, checked at every falling edge.
module sim_mtimer_wb;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [63:0] FREQ = 64'h0000_0012_3456_789A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [4:0]  adr = '0;
    logic [31:0] wdat = '0;
    logic        ack, stall, irq;
    logic [31:0] rdat;

    int checks = 0;
    int fails  = 0;

    // Model state
    logic [63:0] m_time = '0;
    logic [63:0] m_cmp  = '1;
    logic        e_ack  = 1'b0;
    logic        e_read = 1'b0;
    logic [31:0] e_rdat = '0;
    logic [1:0]  e_code = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mtimer_wb #(.CLK_FREQ_HZ(FREQ)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .cyc_i(cyc), .stb_i(stb), .we_i(we),
        .adr_i(adr), .dat_i(wdat), .ack_o(ack), .stall_o(stall),
        .dat_o(rdat), .irq_o(irq)
    );

    function automatic logic [31:0] model_read(input logic [4:0] a);
        logic [63:0] v;
        case (a[4:3])
            2'b00:   v = m_time;
            2'b01:   v = m_cmp;
            2'b10:   v = FREQ;
            default: v = '0;
        endcase
        return a[2] ? v[63:32] : v[31:0];
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: drive at the falling edge, update the model at the rising
    // edge, compare outputs at the next falling edge.
    task automatic step(input logic c, input logic s, input logic w,
                        input logic [4:0] a, input logic [31:0] d);
        cyc = c; stb = s; we = w; adr = a; wdat = d;
        @(posedge clk);
        e_ack  = c && s;
        e_read = c && s && !w;
        e_code = a[4:3];
        if (e_read) e_rdat = model_read(a);
        if (c && s && w && a[4:3] == 2'b00) begin
            if (a[2]) m_time[63:32] = d; else m_time[31:0] = d;
        end else begin
            m_time = m_time + 64'd1;
        end
        if (c && s && w && a[4:3] == 2'b01) begin
            if (a[2]) m_cmp[63:32] = d; else m_cmp[31:0] = d;
        end
        @(negedge clk);
        check("R9 ack", {63'd0, ack}, {63'd0, e_ack});
        check("R9 stall", {63'd0, stall}, 64'd0);
        check("R8 irq", {63'd0, irq}, {63'd0, (m_time >= m_cmp)});
        if (e_ack && e_read)
            check((e_code[1]) ? "R7 read" : "R10 read", {32'd0, rdat}, {32'd0, e_rdat});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 5'd0, 32'd0);
    endtask

    task automatic rd(input logic [4:0] a);
        step(1'b1, 1'b1, 1'b0, a, 32'd0);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        step(1'b1, 1'b1, 1'b1, a, d);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL R9 watchdog: got hang expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: state right after reset
        check("R1 ack", {63'd0, ack}, 64'd0);
        check("R1 irq", {63'd0, irq}, 64'd0);
        check("R1 stall", {63'd0, stall}, 64'd0);
        rd(5'h00);                          // R1: counter starts at zero
        rd(5'h08);                          // R1: compare low half all ones
        idle(5);                            // R2
        rd(5'h03);                          // R3: low address bits ignored
        rd(5'h06);                          // R4: high half of counter
        // R5: load low half near a carry and watch it ripple into the high half
        wr(5'h00, 32'hFFFF_FFFE);
        idle(3);
        rd(5'h04);
        wr(5'h05, 32'h0000_0007);           // R5 high half, byte bits set
        rd(5'h00);
        // R6, R8: compare a little ahead of the counter
        wr(5'h0C, 32'h0000_0007);
        wr(5'h08, m_time[31:0] + 32'd12);
        rd(5'h09); rd(5'h0E);
        idle(14);
        // R7: constant readout, ignored writes, unused code
        rd(5'h10); rd(5'h14); rd(5'h13);
        wr(5'h10, 32'hDEAD_BEEF); wr(5'h14, 32'h1234_5678);
        rd(5'h10); rd(5'h14);
        wr(5'h18, 32'hAAAA_5555); wr(5'h1C, 32'h5555_AAAA);
        rd(5'h18); rd(5'h1F);
        rd(5'h08); rd(5'h0C);
        // R9: strobe without cycle is not a request; back-to-back reads
        step(1'b0, 1'b1, 1'b1, 5'h08, 32'h0);
        step(1'b1, 1'b0, 1'b1, 5'h08, 32'h0);
        rd(5'h08);
        rd(5'h00); rd(5'h04); rd(5'h10);
        // R2, R8: wrap of the counter across 2^64 with a small compare value
        wr(5'h0C, 32'h0); wr(5'h08, 32'h3);
        wr(5'h04, 32'hFFFF_FFFF); wr(5'h00, 32'hFFFF_FFFC);
        idle(10);
        rd(5'h00); rd(5'h04);
        // R8: raising the compare value drops the interrupt
        wr(5'h0C, 32'h1);
        idle(2);
        summary();
        $finish;
    end
endmodule